// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a local requester reach a 16-bit control register space that is hidden behind a small set of 32-bit mailbox registers on a plain memory-mapped bus. The requester hands over one operation at a time: a direction, a register address and, for stores, a 16-bit value. The bridge turns it into the chain of bus transfers the mailbox expects. Every transfer waits for the bus to accept it before the next one starts.

A store places the converted address in the address mailbox, the value in the write-data mailbox and the store command code in the command mailbox. A load places the converted address and the load command code, then keeps reading the result mailbox. It stops when the word carries its ready flag or when a fixed number of reads has been spent. The result status code inside the word decides whether the low half of the word is returned or whether an all-ones value is returned with an error indication. A spent poll budget returns all-ones with a timeout indication.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset `busy`, `ack` and `bus_valid` are all low.
- R2: The first bus transfer of every operation is a write to the address mailbox (`MB_CTRL`, default 0x0000) carrying `(req_addr >> 1) + 0x30000`.
- R3: A store performs exactly three bus writes in order: address mailbox, write-data mailbox (`MB_WDATA`, default 0x0004) carrying `req_wdata` zero-extended, command mailbox (`MB_CMD`, default 0x0008) carrying 1.
- R4: A load performs the address write, then a write of 2 to the command mailbox, then only bus reads of the result mailbox (`MB_RDATA`, default 0x000C).
- R5: While `bus_valid` is high and `bus_ready` low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` hold their values on the next cycle.
- R6: A polled word whose bit 31 (ready) is set and whose bits 30:29 (status) equal 2'b01 ends the load with `rsp_data` equal to bits 15:0 and both flags low.
- R7: A ready word whose status is any value other than 2'b01 ends the load with `rsp_data` = 0xFFFF, `rsp_error` high and `rsp_timeout` low.
- R8: If `POLL_LIMIT` consecutive reads all have bit 31 clear, the load ends after exactly `POLL_LIMIT` reads with `rsp_data` = 0xFFFF, `rsp_timeout` high and `rsp_error` low; a ready word arriving on read `POLL_LIMIT` or earlier is taken normally.
- R9: `req` is taken only while `busy` is low; `busy` stays high from the cycle after acceptance through the `ack` cycle, `ack` is a one-cycle pulse, and a `req` seen while busy starts no transfer.
- R10: A store ends with `ack` one cycle after the command write is accepted, with `rsp_data` = 0 and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Operation request, taken when idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | UAW | Register address in the hidden space |
| req_wdata | input | 16 | Value for a store |
| busy | output | 1 | Operation in progress |
| ack | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Load result (0xFFFF on failure, 0 for stores) |
| rsp_timeout | output | 1 | Poll budget was spent without ready |
| rsp_error | output | 1 | Ready word carried a bad status |
| bus_valid | output | 1 | Bus transfer request |
| bus_write | output | 1 | Bus transfer direction, 1 = write |
| bus_addr | output | BUS_AW | Mailbox address |
| bus_wdata | output | BW | Bus write data |
| bus_rdata | input | BW | Bus read data, valid with bus_ready |
| bus_ready | input | 1 | Bus accepts the current transfer |

## Verification
Loads are swept over every combination of ready delay (zero up to two beyond the poll budget), every 2-bit status code and bus wait states of zero to two cycles. That separates a correct data return from the error and timeout paths and pins the exact boundary where the last allowed read still counts. Stores to a spread of addresses, later read back, tell apart correct address conversion and data placement from a shifted or offset mailbox value. A request pulsed during a running operation checks that the bridge issues no extra transfer.

// File: rtl/irb_pkg.sv
package irb_pkg;

  localparam int DW = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WDATA = 3'd2,
    ST_CMD   = 3'd3,
    ST_POLL  = 3'd4,
    ST_DONE  = 3'd5
  } irb_state_e;

  localparam logic [7:0] OPC_STORE = 8'd1;
  localparam logic [7:0] OPC_LOAD  = 8'd2;

  localparam logic [DW-1:0] FAIL_VAL = {DW{1'b1}};

endpackage

// File: rtl/irb_addr_xform.sv
module irb_addr_xform #(
  parameter int          UAW  = 18,
  parameter int          BW   = 32,
  parameter logic [31:0] BASE = 32'h0003_0000
) (
  input  logic [UAW-1:0] user_addr,
  output logic [BW-1:0]  mbox_addr
);
  localparam int PADW = BW - UAW;

  logic [BW-1:0] widened;

  always_comb begin
    widened   = {{PADW{1'b0}}, user_addr};
    mbox_addr = (widened >> 1) + BASE[BW-1:0];
  end
endmodule

// File: rtl/irb_poll_ctr.sv
module irb_poll_ctr #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] START = CW'(LIMIT);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = START;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == ONE);
endmodule

// File: rtl/irb_rword_dec.sv
module irb_rword_dec #(
  parameter int         BW      = 32,
  parameter int         DW      = 16,
  parameter int         RDY_BIT = 31,
  parameter int         ST_LSB  = 29,
  parameter logic [1:0] ST_OK   = 2'b01
) (
  input  logic [BW-1:0] word,
  output logic          rdy,
  output logic          ok,
  output logic [DW-1:0] val
);
  logic [1:0] status;

  always_comb begin
    rdy    = word[RDY_BIT];
    status = word[ST_LSB +: 2];
    ok     = (status == ST_OK);
    val    = word[DW-1:0];
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import irb_pkg::*;
#(
  parameter int          UAW        = 18,
  parameter int          BUS_AW     = 16,
  parameter int          BW         = 32,
  parameter int          POLL_LIMIT = 32,
  parameter logic [31:0] XFORM_BASE = 32'h0003_0000,
  parameter logic [15:0] MB_CTRL    = 16'h0000,
  parameter logic [15:0] MB_WDATA   = 16'h0004,
  parameter logic [15:0] MB_CMD     = 16'h0008,
  parameter logic [15:0] MB_RDATA   = 16'h000C,
  parameter int          RDY_BIT    = 31,
  parameter int          ST_LSB     = 29,
  parameter logic [1:0]  ST_OK      = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_write,
  input  logic [UAW-1:0]    req_addr,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              ack,
  output logic [15:0]       rsp_data,
  output logic              rsp_timeout,
  output logic              rsp_error,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [BW-1:0]     bus_wdata,
  input  logic [BW-1:0]     bus_rdata,
  input  logic              bus_ready
);
  localparam int DPAD = BW - DW;
  localparam int OPAD = BW - 8;

  irb_state_e state_q, state_d;

  // captured operation
  logic           op_wr_q;
  logic [UAW-1:0] op_addr_q;
  logic [DW-1:0]  op_data_q;
  logic           op_cap;

  // response registers
  logic [DW-1:0]  res_data_q, res_data_d;
  logic           res_to_q, res_to_d;
  logic           res_err_q, res_err_d;
  logic           res_en;

  logic           hs;
  logic [BW-1:0]  mbox_addr;
  logic           rw_rdy, rw_ok;
  logic [DW-1:0]  rw_val;
  logic           pc_load, pc_dec, pc_last;

  irb_addr_xform #(.UAW(UAW), .BW(BW), .BASE(XFORM_BASE)) u_xform (
    .user_addr (op_addr_q),
    .mbox_addr (mbox_addr)
  );

  irb_rword_dec #(
    .BW(BW), .DW(DW), .RDY_BIT(RDY_BIT), .ST_LSB(ST_LSB), .ST_OK(ST_OK)
  ) u_dec (
    .word (bus_rdata),
    .rdy  (rw_rdy),
    .ok   (rw_ok),
    .val  (rw_val)
  );

  irb_poll_ctr #(.LIMIT(POLL_LIMIT)) u_pctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (pc_load),
    .dec   (pc_dec),
    .last  (pc_last)
  );

  assign hs     = bus_valid & bus_ready;
  assign op_cap = (state_q == ST_IDLE) & req;

  // counter control: arm after the load command, spend one per empty read
  assign pc_load = (state_q == ST_CMD) & hs & ~op_wr_q;
  assign pc_dec  = (state_q == ST_POLL) & hs & ~rw_rdy;

  // next state and response
  always_comb begin
    state_d    = state_q;
    res_en     = 1'b0;
    res_data_d = res_data_q;
    res_to_d   = res_to_q;
    res_err_d  = res_err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req) state_d = ST_ADDR;
      end
      ST_ADDR: begin
        if (hs) state_d = op_wr_q ? ST_WDATA : ST_CMD;
      end
      ST_WDATA: begin
        if (hs) state_d = ST_CMD;
      end
      ST_CMD: begin
        if (hs) begin
          if (op_wr_q) begin
            state_d    = ST_DONE;
            res_en     = 1'b1;
            res_data_d = '0;
            res_to_d   = 1'b0;
            res_err_d  = 1'b0;
          end else begin
            state_d = ST_POLL;
          end
        end
      end
      ST_POLL: begin
        if (hs) begin
          if (rw_rdy) begin
            state_d    = ST_DONE;
            res_en     = 1'b1;
            res_to_d   = 1'b0;
            res_err_d  = ~rw_ok;
            res_data_d = rw_ok ? rw_val : FAIL_VAL;
          end else if (pc_last) begin
            state_d    = ST_DONE;
            res_en     = 1'b1;
            res_to_d   = 1'b1;
            res_err_d  = 1'b0;
            res_data_d = FAIL_VAL;
          end
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q   <= 1'b0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else if (op_cap) begin
      op_wr_q   <= req_write;
      op_addr_q <= req_addr;
      op_data_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data_q <= '0;
      res_to_q   <= 1'b0;
      res_err_q  <= 1'b0;
    end else if (res_en) begin
      res_data_q <= res_data_d;
      res_to_q   <= res_to_d;
      res_err_q  <= res_err_d;
    end
  end

  // bus drive from state
  always_comb begin
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    unique case (state_q)
      ST_ADDR: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = MB_CTRL[BUS_AW-1:0];
        bus_wdata = mbox_addr;
      end
      ST_WDATA: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = MB_WDATA[BUS_AW-1:0];
        bus_wdata = {{DPAD{1'b0}}, op_data_q};
      end
      ST_CMD: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = MB_CMD[BUS_AW-1:0];
        bus_wdata = {{OPAD{1'b0}}, (op_wr_q ? OPC_STORE : OPC_LOAD)};
      end
      ST_POLL: begin
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = MB_RDATA[BUS_AW-1:0];
      end
      default: begin
        bus_valid = 1'b0;
      end
    endcase
  end

  assign busy        = (state_q != ST_IDLE);
  assign ack         = (state_q == ST_DONE);
  assign rsp_data    = res_data_q;
  assign rsp_timeout = res_to_q;
  assign rsp_error   = res_err_q;

endmodule

// File: rtl/irb_checker.sv
module irb_checker #(
  parameter int BUS_AW = 16,
  parameter int BW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              busy,
  input logic              ack,
  input logic [15:0]       rsp_data,
  input logic              rsp_timeout,
  input logic              rsp_error,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BW-1:0]     bus_wdata,
  input logic              bus_ready
);

  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_write) &&
                                   $stable(bus_addr) && $stable(bus_wdata)));

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r9_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> busy);

  a_r9_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> busy);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

  a_r8_timeout_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rsp_timeout) |-> (rsp_data == 16'hFFFF && !rsp_error));

  a_r7_error_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rsp_error) |-> (rsp_data == 16'hFFFF && !rsp_timeout));

endmodule

bind ind_reg_bridge irb_checker #(.BUS_AW(BUS_AW), .BW(BW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .busy        (busy),
  .ack         (ack),
  .rsp_data    (rsp_data),
  .rsp_timeout (rsp_timeout),
  .rsp_error   (rsp_error),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_ready   (bus_ready)
);

// File: tb/ind_reg_bridge_tb.sv
module ind_reg_bridge_tb;
  localparam int LIM = 4;
  localparam logic [15:0] A_CTRL = 16'h0000;
  localparam logic [15:0] A_WD   = 16'h0004;
  localparam logic [15:0] A_CMD  = 16'h0008;
  localparam logic [15:0] A_RD   = 16'h000C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, ack, rsp_timeout, rsp_error;
  logic [15:0] rsp_data;
  logic        bus_valid, bus_write, bus_ready;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  ind_reg_bridge #(.POLL_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .ack(ack),
    .rsp_data(rsp_data), .rsp_timeout(rsp_timeout), .rsp_error(rsp_error),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bus-side model of the mailbox and register space
  int          wait_cfg = 0;
  int          poll_cfg = 0;
  logic [1:0]  stat_cfg = 2'b01;
  int          wcnt = 0;
  logic [31:0] m_ctrl = '0;
  logic [31:0] m_wd = '0;
  int          m_poll = 0;
  logic [5:0]  m_idx = '0;
  logic [15:0] m_mem [64];
  logic [15:0] e_mem [64];

  logic [31:0] lg_addr [16];
  logic [31:0] lg_data [16];
  logic        lg_we   [16];
  int          lg_n = 0;
  int          stall_bad = 0;
  logic        p_stall = 1'b0;
  logic [15:0] p_addr = '0;
  logic [31:0] p_wdata = '0;
  logic        p_we = 1'b0;

  assign bus_ready = bus_valid && (wcnt >= wait_cfg);
  assign bus_rdata = (m_poll == 0) ? {1'b1, stat_cfg, 13'h0, m_mem[m_idx]}
                                   : {1'b0, 2'b01, 13'h0, 16'hABCD};

  always @(posedge clk) begin
    if (rst_n) begin
      if (p_stall && (!bus_valid || bus_addr != p_addr ||
                      bus_wdata != p_wdata || bus_write != p_we))
        stall_bad = stall_bad + 1;
      p_stall = bus_valid && !bus_ready;
      p_addr  = bus_addr;
      p_wdata = bus_wdata;
      p_we    = bus_write;
      if (bus_valid && bus_ready) begin
        if (lg_n < 16) begin
          lg_addr[lg_n] = {16'h0, bus_addr};
          lg_data[lg_n] = bus_write ? bus_wdata : 32'h0;
          lg_we[lg_n]   = bus_write;
        end
        lg_n = lg_n + 1;
        wcnt <= 0;
        if (bus_write) begin
          if (bus_addr == A_CTRL) m_ctrl <= bus_wdata;
          if (bus_addr == A_WD)   m_wd   <= bus_wdata;
          if (bus_addr == A_CMD && bus_wdata == 32'd1) m_mem[m_ctrl[5:0]] <= m_wd[15:0];
          if (bus_addr == A_CMD && bus_wdata == 32'd2) begin
            m_poll <= poll_cfg;
            m_idx  <= m_ctrl[5:0];
          end
        end else if (bus_addr == A_RD && m_poll != 0) begin
          m_poll <= m_poll - 1;
        end
      end else if (bus_valid) begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic txn(input bit wr, input logic [17:0] a, input logic [15:0] d,
                     input bit poke);
    int k;
    int exp_n;
    int reads;
    logic [15:0] ed;
    logic [31:0] ea;
    @(negedge clk);
    lg_n = 0;
    req = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", {31'h0, busy}, 32'h1);
    if (poke) begin
      req = 1'b1; req_write = 1'b1; req_addr = a ^ 18'h2; req_wdata = ~d;
      @(negedge clk);
      req = 1'b0;
    end
    k = 0;
    while (!ack && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(ack == 1'b1, "R9 ack seen", {31'h0, ack}, 32'h1);
    ea = ({14'h0, a} >> 1) + 32'h0003_0000;
    chk(lg_addr[0] == {16'h0, A_CTRL} && lg_we[0] && lg_data[0] == ea,
        "R2 address mailbox write", lg_data[0], ea);
    if (wr) begin
      e_mem[(a >> 1) & 18'h3F] = d;
      chk(lg_n == 3, "R3 store transfer count", lg_n, 3);
      chk(lg_addr[1] == {16'h0, A_WD} && lg_we[1] && lg_data[1] == {16'h0, d},
          "R3 data mailbox", lg_data[1], {16'h0, d});
      chk(lg_addr[2] == {16'h0, A_CMD} && lg_we[2] && lg_data[2] == 32'd1,
          "R3 store command", lg_data[2], 32'd1);
      chk(rsp_data == 16'h0 && !rsp_timeout && !rsp_error, "R10 store response",
          {14'h0, rsp_timeout, rsp_error, rsp_data}, 32'h0);
    end else begin
      reads = (poll_cfg < LIM) ? poll_cfg + 1 : LIM;
      exp_n = 2 + reads;
      chk(lg_n == exp_n, "R4 R8 load transfer count", lg_n, exp_n);
      chk(lg_addr[1] == {16'h0, A_CMD} && lg_we[1] && lg_data[1] == 32'd2,
          "R4 load command", lg_data[1], 32'd2);
      for (int j = 2; j < exp_n && j < 16; j++)
        chk(lg_addr[j] == {16'h0, A_RD} && !lg_we[j], "R4 poll read",
            lg_addr[j], {16'h0, A_RD});
      if (poll_cfg >= LIM) begin
        chk(rsp_data == 16'hFFFF && rsp_timeout && !rsp_error, "R8 timeout",
            {14'h0, rsp_timeout, rsp_error, rsp_data}, {14'h0, 2'b10, 16'hFFFF});
      end else if (stat_cfg == 2'b01) begin
        ed = e_mem[(a >> 1) & 18'h3F];
        chk(rsp_data == ed && !rsp_timeout && !rsp_error, "R6 good load",
            {14'h0, rsp_timeout, rsp_error, rsp_data}, {16'h0, ed});
      end else begin
        chk(rsp_data == 16'hFFFF && !rsp_timeout && rsp_error, "R7 bad status",
            {14'h0, rsp_timeout, rsp_error, rsp_data}, {14'h0, 2'b01, 16'hFFFF});
      end
    end
    exp_n = lg_n;
    @(negedge clk);
    chk(!ack && !busy, "R9 ack pulse and idle", {30'h0, ack, busy}, 32'h0);
    if (poke) begin
      repeat (8) @(negedge clk);
      chk(lg_n == exp_n && !busy, "R9 request while busy ignored", lg_n, exp_n);
    end
  endtask

  logic [17:0] alist [6];
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_mem[i] = 16'h0;
      e_mem[i] = 16'h0;
    end
    alist[0] = 18'h00000; alist[1] = 18'h00002; alist[2] = 18'h0007E;
    alist[3] = 18'h01235; alist[4] = 18'h3FFFE; alist[5] = 18'h2A54C;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !ack && !bus_valid, "R1 reset outputs",
        {29'h0, busy, ack, bus_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_valid, "R1 idle after release", {30'h0, busy, bus_valid}, 32'h0);
    // stores across addresses and wait states
    for (int i = 0; i < 6; i++) begin
      wait_cfg = i % 3;
      txn(1'b1, alist[i], 16'h1357 * 16'(i + 1) ^ 16'h8001, 1'b0);
    end
    // request during busy
    wait_cfg = 2;
    txn(1'b1, alist[2], 16'hC0DE, 1'b1);
    // loads: ready delay x status x wait states
    for (int dl = 0; dl <= LIM + 1; dl++)
      for (int st = 0; st < 4; st++)
        for (int w = 0; w < 3; w++) begin
          poll_cfg = dl;
          stat_cfg = 2'(st);
          wait_cfg = w;
          txn(1'b0, alist[(dl + st + w) % 6], 16'h0, 1'b0);
        end
    // R5 stall stability
    chk(stall_bad == 0, "R5 stalled transfer stable", stall_bad, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule